// File: doc/BRIEF.md
# Sector Decoder Run Control

This unit decides when a sector-based optical disc data decoder is running. Software drives it through one 8-bit control register that holds a subcode enable, a decode enable and a forced-stop bit. The unit then steps through four phases: idle, waiting for sync, running, and finishing the current sector. Two outputs, decode-active and subcode-active, tell the rest of the decoder pipeline whether it may process data.

A start does not take effect when it is written. Decoding begins at the next valid sync strobe. A plain disable lets the sector in progress complete, and decoding ends at the end-of-sector strobe. A forced stop ends decoding at once. An abnormal-condition strobe also stops decoding. In both of those cases the hardware clears the enable bits itself, and when a hardware clear lands in the same cycle as a software write, the hardware clear wins.

Top module: `sector_run_ctrl`

## Requirements
- R1: The register reads back as {subcode enable in bit 7, decode enable in bit 6, forced-stop in bit 5, bits 4..0 = 0}. Writes to bits 4..0 are ignored, and every bit resets to 0.
- R2: Setting the decode enable does not raise decode_active. The unit first waits one cycle, then watches for sync. decode_active goes high in the cycle after a sync strobe is sampled in the waiting phase.
- R3: A sync strobe sampled while idle is ignored and leaves decode_active low.
- R4: When the decode enable is cleared while decoding, decode_active stays high until an end-of-sector strobe. It goes low in the cycle after that strobe.
- R5: An end-of-sector strobe while the decode enable is still set keeps decode_active high.
- R6: Setting the decode enable again while finishing cancels the pending stop. A later end-of-sector strobe then keeps decode_active high.
- R7: A write with bit 5 = 1 drives decode_active low in the cycle after the write. The same write clears both enable bits, and readback shows 0x20.
- R8: While the stored forced-stop bit is 1, enable bits in a write are discarded. Only a write made after bit 5 has been cleared can start decoding again.
- R9: An abnormal strobe drives decode_active low and clears both enable bits in the next cycle.
- R10: When an abnormal strobe and a register write land in the same cycle, the enable bits end up 0.
- R11: subcode_active equals the subcode enable ANDed with decode_active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| sync_det | input | 1 | Valid sync detected strobe |
| sector_end | input | 1 | End-of-sector strobe |
| abnormal | input | 1 | Abnormal-condition strobe |
| rd_data | output | 8 | Register readback |
| decode_active | output | 1 | Decoder is processing a sector |
| subcode_active | output | 1 | Subcode processing is active |

## Verification
The register contents and readback change at the clock edge that samples the write. A start reaches the sync-waiting phase one edge after the write, and decode_active rises at the edge that samples a sync in that phase. Forced stop, abnormal and end-of-sector each take decode_active low at the edge that samples them. The bench drives every input on the falling edge and samples the outputs on the following falling edge. Before each sync it inserts an extra falling edge, so that the sync is timed against the waiting phase rather than idle.

// File: rtl/sector_run_pkg.sv
package sector_run_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_RUN    = 2'd2,
    ST_FINISH = 2'd3
  } run_state_t;

  localparam int unsigned SUB_BIT  = 7;
  localparam int unsigned DEC_BIT  = 6;
  localparam int unsigned STOP_BIT = 5;

  function automatic logic is_active(input run_state_t s);
    return (s == ST_RUN) || (s == ST_FINISH);
  endfunction

  function automatic logic [7:0] pack_ctrl(input logic sub, input logic dec, input logic stp);
    logic [7:0] v;
    v = '0;
    v[SUB_BIT]  = sub;
    v[DEC_BIT]  = dec;
    v[STOP_BIT] = stp;
    return v;
  endfunction
endpackage

// File: rtl/run_ctrl_reg.sv
module run_ctrl_reg
  import sector_run_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             abnormal,
  output logic             sub_en,
  output logic             dec_en,
  output logic             stop_q,
  output logic             kill,
  output logic [REG_W-1:0] rd_data
);
  logic stop_wr;
  logic hw_clr;

  assign stop_wr = wr_en & wr_data[STOP_BIT];
  assign kill    = stop_wr | stop_q;
  assign hw_clr  = kill | abnormal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_en <= 1'b0;
      dec_en <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      if (wr_en) stop_q <= wr_data[STOP_BIT];
      if (hw_clr) begin
        sub_en <= 1'b0;
        dec_en <= 1'b0;
      end else if (wr_en) begin
        sub_en <= wr_data[SUB_BIT];
        dec_en <= wr_data[DEC_BIT];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[7:0] = pack_ctrl(sub_en, dec_en, stop_q);
  end

  // R9 R10
  enable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abnormal || stop_wr) |=> (!dec_en && !sub_en));

  // R8
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> !dec_en);
endmodule

// File: rtl/run_ctrl_fsm.sv
module run_ctrl_fsm
  import sector_run_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dec_en,
  input  logic kill,
  input  logic abnormal,
  input  logic sync_det,
  input  logic sector_end,
  output logic active
);
  run_state_t state_q, state_d;
  logic halt;

  assign halt = kill | abnormal;

  always_comb begin
    state_d = state_q;
    if (halt) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:   if (dec_en) state_d = ST_WAIT;
        ST_WAIT:   if (!dec_en) state_d = ST_IDLE;
                   else if (sync_det) state_d = ST_RUN;
        ST_RUN:    if (!dec_en) state_d = sector_end ? ST_IDLE : ST_FINISH;
        ST_FINISH: if (dec_en) state_d = ST_RUN;
                   else if (sector_end) state_d = ST_IDLE;
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign active = is_active(state_q);

  // R7 R9
  halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !active);

  // R2
  sync_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !(state_q == ST_WAIT && sync_det)) |=> !active);

  // R3
  idle_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && sync_det) |=> !active);

  // R4
  finish_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FINISH && !sector_end && !halt) |=> active);
endmodule

// File: rtl/sector_run_ctrl.sv
module sector_run_ctrl
  import sector_run_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             sync_det,
  input  logic             sector_end,
  input  logic             abnormal,
  output logic [REG_W-1:0] rd_data,
  output logic             decode_active,
  output logic             subcode_active
);
  logic sub_en, dec_en, stop_q, kill;

  run_ctrl_reg #(.REG_W(REG_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .abnormal(abnormal), .sub_en(sub_en), .dec_en(dec_en),
    .stop_q(stop_q), .kill(kill), .rd_data(rd_data)
  );

  run_ctrl_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .kill(kill),
    .abnormal(abnormal), .sync_det(sync_det), .sector_end(sector_end),
    .active(decode_active)
  );

  assign subcode_active = sub_en & decode_active;

  // R11
  subcode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    subcode_active |-> (decode_active && rd_data[SUB_BIT]));
endmodule

// File: tb/sector_run_ctrl_bench.sv
module sector_run_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic sync_det = 1'b0, sector_end = 1'b0, abnormal = 1'b0;
  logic [7:0] rd_data;
  logic decode_active, subcode_active;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  sector_run_ctrl u_sector_run_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .sync_det(sync_det), .sector_end(sector_end), .abnormal(abnormal),
    .rd_data(rd_data), .decode_active(decode_active), .subcode_active(subcode_active)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse_sync();
    sync_det = 1'b1; @(negedge clk); sync_det = 1'b0;
  endtask

  task automatic pulse_end();
    sector_end = 1'b1; @(negedge clk); sector_end = 1'b0;
  endtask

  task automatic pulse_abn();
    abnormal = 1'b1; @(negedge clk); abnormal = 1'b0;
  endtask

  task automatic start_run();
    wr(8'hC0); idle(1); pulse_sync();
  endtask

  task automatic t_reset();
    chk("R1 reset rd", rd_data, 8'h00);
    chk("R1 reset dec", {7'b0, decode_active}, 8'h00);
    chk("R11 reset sub", {7'b0, subcode_active}, 8'h00);
  endtask

  task automatic t_register();
    wr(8'h1F); chk("R1 reserved", rd_data, 8'h00);
    wr(8'hDF); chk("R1 layout", rd_data, 8'hC0);
    wr(8'h00);
  endtask

  task automatic t_start();
    wr(8'hC0);
    pulse_sync();
    chk("R3 idle sync ignored", {7'b0, decode_active}, 8'h00);
    idle(3);
    chk("R2 no start without sync", {7'b0, decode_active}, 8'h00);
    pulse_sync();
    chk("R2 started", {7'b0, decode_active}, 8'h01);
    chk("R11 sub on", {7'b0, subcode_active}, 8'h01);
    pulse_end();
    chk("R5 continue", {7'b0, decode_active}, 8'h01);
  endtask

  task automatic t_graceful();
    wr(8'h00); idle(3);
    chk("R4 finishing", {7'b0, decode_active}, 8'h01);
    chk("R11 sub gated", {7'b0, subcode_active}, 8'h00);
    pulse_end();
    chk("R4 stopped", {7'b0, decode_active}, 8'h00);
  endtask

  task automatic t_cancel();
    start_run();
    wr(8'h00); idle(1);
    wr(8'hC0); pulse_end(); idle(2);
    chk("R6 cancel", {7'b0, decode_active}, 8'h01);
  endtask

  task automatic t_force();
    wr(8'hE0);
    chk("R7 immediate", {7'b0, decode_active}, 8'h00);
    chk("R7 readback", rd_data, 8'h20);
    wr(8'h40);
    chk("R8 enable discarded", rd_data, 8'h00);
    idle(1); pulse_sync();
    chk("R8 no restart", {7'b0, decode_active}, 8'h00);
    wr(8'h40);
    chk("R8 accepted", rd_data, 8'h40);
    idle(1); pulse_sync();
    chk("R8 restarted", {7'b0, decode_active}, 8'h01);
  endtask

  task automatic t_abnormal();
    pulse_abn();
    chk("R9 stopped", {7'b0, decode_active}, 8'h00);
    chk("R9 cleared", rd_data, 8'h00);
    abnormal = 1'b1; wr(8'hC0); abnormal = 1'b0;
    chk("R10 hw wins", rd_data, 8'h00);
  endtask

  initial begin
    idle(2); rst_n = 1'b1; idle(1);
    t_reset();
    t_register();
    t_start();
    t_graceful();
    t_cancel();
    t_force();
    t_abnormal();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule